// File: doc/BRIEF.md
# Power-Mode Controller with Watchdog Gate

This block is the supervisory sequencer of a system-basis companion device. It holds one of six operating modes and drives the outputs that follow from that mode: the main-regulator enable and its low-power keep-alive flag, the secondary-regulator enable, the active-low reset line and the high-side switch enable. Its inputs are wake events, reset causes and mode commands that SPI decode logic elsewhere has already turned into strobes. All durations count a tick-enable input (nominally one millisecond), so a bench can shrink them to a few clock cycles.

After power-up or a wake from Sleep, the block holds reset for a fixed number of ticks. It then waits in a request mode for a watchdog configuration write. A wake from Stop skips the reset phase. If the request mode times out, the next mode depends on where the last wake came from. Once configured, a windowed watchdog guards Normal and Standby. It also guards Stop when a stored enable allows it.

Top module: `pmc_ctrl`

## Requirements
- R1: Reset mode (mode_o=0) holds rst_no low with vdd_en_o high and v2_en_o low. It lasts exactly RST_TICKS ticks with vdd_uv_i low, and then enters Normal Request (mode_o=1). Release of rst_ni enters Reset mode.
- R2: Normal Request has vdd_en_o=1, v2_en_o=0 and rst_no=1. A cycle with wd_cfg_i high loads wd_period_i and moves to Standby (mode_o=3) if the same cycle carries cmd_vld_i with cmd_code_i=3; otherwise it moves to Normal (mode_o=2). A configuration write in the final tick of the window still wins over the timeout.
- R3: Without a configuration write, Normal Request ends after NREQ_TICKS ticks. It then goes to Sleep (mode_o=5) if the last wake came from Sleep, and to Reset otherwise (power-up, Stop wake, fault reset).
- R4: In Sleep, any bit of wake_src_i (bit 0 level change, bit 1 cyclic sense, bit 2 wake timer, bit 3 CAN activity) moves to Reset. cs_wake_i, vdd_oc_i, vdd_uv_i and commands are ignored in Sleep.
- R5: In Stop (mode_o=4), any bit of wake_src_i, cs_wake_i or vdd_oc_i moves directly to Normal Request.
- R6: Per mode: Normal has vdd_en_o=1 and v2_en_o=1. Standby has vdd_en_o=1 and v2_en_o=0. Stop has vdd_en_o=1, vdd_lp_o=1 and v2_en_o=0. Sleep has vdd_en_o=0 and v2_en_o=0. vdd_lp_o is high only in Stop.
- R7: In Normal or Standby, the watchdog moves to Reset after a full configured period of ticks without a trigger.
- R8: A wd_trig_i that arrives while the count since the last clear is below half the period moves to Reset. A trigger in the open half restarts the period.
- R9: In Stop, the watchdog count halts when wd_stop_en_i=0. When wd_stop_en_i=1 it keeps counting, and expiry moves to Reset.
- R10: vdd_uv_i in any mode except Sleep forces Reset at the next edge, before any other event. While it stays high, the Reset timer stays cleared.
- R11: In Normal and Standby, a cmd_vld_i strobe with code 2 (Normal), 3 (Standby), 4 (Stop) or 5 (Sleep) selects that mode. Other codes, and commands in any other mode, are ignored.
- R12: hs_en_o equals hs_req_i in Normal and Standby and is low in every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up) |
| tick_i | input | 1 | Time-base enable, one per timer tick |
| vdd_uv_i | input | 1 | Main-supply undervoltage |
| vdd_oc_i | input | 1 | Main-supply overcurrent (Stop wake) |
| wake_src_i | input | WAKE_N | Wake event sources |
| cs_wake_i | input | 1 | Chip-select activity (Stop wake) |
| cmd_vld_i | input | 1 | Mode command strobe |
| cmd_code_i | input | 3 | Mode command target code |
| wd_cfg_i | input | 1 | Watchdog period configuration strobe |
| wd_period_i | input | PER_W | Watchdog period in ticks |
| wd_trig_i | input | 1 | Watchdog clear strobe |
| wd_stop_en_i | input | 1 | Watchdog keeps running in Stop |
| hs_req_i | input | 1 | High-side switch request |
| mode_o | output | 3 | Current mode code |
| vdd_en_o | output | 1 | Main regulator enable |
| vdd_lp_o | output | 1 | Main regulator low-power keep-alive |
| v2_en_o | output | 1 | Secondary regulator enable |
| rst_no | output | 1 | Active-low reset output |
| hs_en_o | output | 1 | High-side switch enable |

## Verification
There are two same-cycle collisions. The first is a configuration write in the last tick of the request window, where the timeout would fire in the same cycle. The bench counts nine ticks into the request window and writes the configuration on the tenth. It then expects Normal rather than Reset. The second is undervoltage together with a Stop command in Normal: the bench drives both in one cycle and expects Reset, with the Reset mode then stretched for as long as the undervoltage stays high.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    M_RESET   = 3'd0,
    M_NREQ    = 3'd1,
    M_NORMAL  = 3'd2,
    M_STANDBY = 3'd3,
    M_STOP    = 3'd4,
    M_SLEEP   = 3'd5
  } pmode_e;
endpackage

// File: rtl/pmc_timer.sv
module pmc_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign done_o = en_i && !clr_i && tick_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || done_o)   cnt_q <= '0;
    else if (en_i && tick_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pmc_wdog.sv
module pmc_wdog #(
  parameter int unsigned PER_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             trig_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_i,
  output logic             early_o,
  output logic             tout_o
);
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] half;

  assign half    = period_i >> 1;
  assign early_o = run_i && trig_i && (cnt_q < half);
  // open-window trigger beats expiry in the same cycle
  assign tout_o  = run_i && tick_i && !trig_i &&
                   (({1'b0, cnt_q} + 1'b1) >= {1'b0, period_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || trig_i) cnt_q <= '0;
    else if (tick_i)           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl #(
  parameter int unsigned RST_TICKS  = 2,
  parameter int unsigned NREQ_TICKS = 350,
  parameter int unsigned PER_W      = 8,
  parameter int unsigned PER_DEF    = 100,
  parameter int unsigned WAKE_N     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              vdd_uv_i,
  input  logic              vdd_oc_i,
  input  logic [WAKE_N-1:0] wake_src_i,
  input  logic              cs_wake_i,
  input  logic              cmd_vld_i,
  input  logic [2:0]        cmd_code_i,
  input  logic              wd_cfg_i,
  input  logic [PER_W-1:0]  wd_period_i,
  input  logic              wd_trig_i,
  input  logic              wd_stop_en_i,
  input  logic              hs_req_i,
  output logic [2:0]        mode_o,
  output logic              vdd_en_o,
  output logic              vdd_lp_o,
  output logic              v2_en_o,
  output logic              rst_no,
  output logic              hs_en_o
);
  import pmc_pkg::*;

  pmode_e           mode_q, mode_d;
  logic             from_sleep_q, from_sleep_d;
  logic [PER_W-1:0] per_q;
  logic             rst_done, nreq_done, wd_early, wd_tout;
  logic             wd_run, act_mode, any_wake;

  assign act_mode = (mode_q == M_NORMAL) || (mode_q == M_STANDBY);
  assign wd_run   = act_mode || ((mode_q == M_STOP) && wd_stop_en_i);
  assign any_wake = |wake_src_i;

  pmc_timer #(.LIMIT(RST_TICKS)) u_rst_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  ((mode_q != M_RESET) || vdd_uv_i),
    .en_i   (mode_q == M_RESET),
    .tick_i (tick_i),
    .done_o (rst_done)
  );

  pmc_timer #(.LIMIT(NREQ_TICKS)) u_nreq_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (mode_q != M_NREQ),
    .en_i   (mode_q == M_NREQ),
    .tick_i (tick_i),
    .done_o (nreq_done)
  );

  pmc_wdog #(.PER_W(PER_W)) u_wdog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (wd_run),
    .trig_i   (wd_trig_i && act_mode),
    .tick_i   (tick_i),
    .period_i (per_q),
    .early_o  (wd_early),
    .tout_o   (wd_tout)
  );

  always_comb begin
    mode_d       = mode_q;
    from_sleep_d = from_sleep_q;
    unique case (mode_q)
      M_RESET: if (rst_done) mode_d = M_NREQ;
      M_NREQ: begin
        if (wd_cfg_i) begin
          mode_d       = (cmd_vld_i && cmd_code_i == 3'd3) ? M_STANDBY : M_NORMAL;
          from_sleep_d = 1'b0;
        end else if (nreq_done) begin
          mode_d = from_sleep_q ? M_SLEEP : M_RESET;
        end
      end
      M_NORMAL, M_STANDBY: begin
        if (wd_early || wd_tout) begin
          mode_d = M_RESET;
        end else if (cmd_vld_i) begin
          case (cmd_code_i)
            3'd2, 3'd3, 3'd4, 3'd5: mode_d = pmode_e'(cmd_code_i);
            default: ;
          endcase
        end
      end
      M_STOP: begin
        if (wd_tout) begin
          mode_d = M_RESET;
        end else if (any_wake || cs_wake_i || vdd_oc_i) begin
          mode_d       = M_NREQ;
          from_sleep_d = 1'b0;
        end
      end
      M_SLEEP: begin
        if (any_wake) begin
          mode_d       = M_RESET;
          from_sleep_d = 1'b1;
        end
      end
      default: mode_d = M_RESET;
    endcase
    if (vdd_uv_i && mode_q != M_SLEEP) begin
      mode_d       = M_RESET;
      from_sleep_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q       <= M_RESET;
      from_sleep_q <= 1'b0;
      per_q        <= PER_W'(PER_DEF);
    end else begin
      mode_q       <= mode_d;
      from_sleep_q <= from_sleep_d;
      if (mode_q == M_NREQ && wd_cfg_i && !vdd_uv_i) per_q <= wd_period_i;
    end
  end

  assign mode_o   = mode_q;
  assign vdd_en_o = (mode_q != M_SLEEP);
  assign vdd_lp_o = (mode_q == M_STOP);
  assign v2_en_o  = (mode_q == M_NORMAL);
  assign rst_no   = (mode_q != M_RESET);
  assign hs_en_o  = hs_req_i && act_mode;
endmodule

// File: rtl/pmc_ctrl_chk.sv
module pmc_ctrl_chk #(
  parameter int unsigned WAKE_N = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vdd_uv_i,
  input logic              vdd_oc_i,
  input logic [WAKE_N-1:0] wake_src_i,
  input logic              cs_wake_i,
  input logic              wd_stop_en_i,
  input logic [2:0]        mode_o,
  input logic              vdd_en_o,
  input logic              vdd_lp_o,
  input logic              v2_en_o,
  input logic              rst_no
);
  // R4
  sleep_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd5 && |wake_src_i) |=> (mode_o == 3'd0));

  // R4
  sleep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd5 && !(|wake_src_i)) |=> (mode_o == 3'd5));

  // R5
  stop_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd4 && !vdd_uv_i && !wd_stop_en_i &&
     (cs_wake_i || vdd_oc_i || |wake_src_i)) |=> (mode_o == 3'd1));

  // R10
  uv_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vdd_uv_i && mode_o != 3'd5) |=> (mode_o == 3'd0 && !rst_no));

  // R6
  v2_supply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v2_en_o |-> (vdd_en_o && rst_no && !vdd_lp_o));

  // R2
  nreq_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd1 && $past(mode_o) != 3'd1) |->
    ($past(mode_o) == 3'd0 || $past(mode_o) == 3'd4));
endmodule

bind pmc_ctrl pmc_ctrl_chk #(.WAKE_N(WAKE_N)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .vdd_uv_i     (vdd_uv_i),
  .vdd_oc_i     (vdd_oc_i),
  .wake_src_i   (wake_src_i),
  .cs_wake_i    (cs_wake_i),
  .wd_stop_en_i (wd_stop_en_i),
  .mode_o       (mode_o),
  .vdd_en_o     (vdd_en_o),
  .vdd_lp_o     (vdd_lp_o),
  .v2_en_o      (v2_en_o),
  .rst_no       (rst_no)
);

// File: tb/sim_pmc_ctrl.sv
module sim_pmc_ctrl;
  localparam int RST_T  = 4;
  localparam int NREQ_T = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       tick_i, vdd_uv_i, vdd_oc_i, cs_wake_i, cmd_vld_i;
  logic [3:0] wake_src_i;
  logic [2:0] cmd_code_i;
  logic       wd_cfg_i, wd_trig_i, wd_stop_en_i, hs_req_i;
  logic [7:0] wd_period_i;
  logic [2:0] mode_o;
  logic       vdd_en_o, vdd_lp_o, v2_en_o, rst_no, hs_en_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  pmc_ctrl #(.RST_TICKS(RST_T), .NREQ_TICKS(NREQ_T), .PER_W(8),
             .PER_DEF(100), .WAKE_N(4)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .vdd_uv_i(vdd_uv_i),
    .vdd_oc_i(vdd_oc_i), .wake_src_i(wake_src_i), .cs_wake_i(cs_wake_i),
    .cmd_vld_i(cmd_vld_i), .cmd_code_i(cmd_code_i), .wd_cfg_i(wd_cfg_i),
    .wd_period_i(wd_period_i), .wd_trig_i(wd_trig_i),
    .wd_stop_en_i(wd_stop_en_i), .hs_req_i(hs_req_i), .mode_o(mode_o),
    .vdd_en_o(vdd_en_o), .vdd_lp_o(vdd_lp_o), .v2_en_o(v2_en_o),
    .rst_no(rst_no), .hs_en_o(hs_en_o)
  );

  function automatic int exp_cmd(int cur, bit vld, int code);
    if (vld && (code == 2 || code == 3)) return code;
    return cur;
  endfunction

  function automatic bit exp_hs(int m, bit req);
    return req && (m == 2 || m == 3);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic idle();
    vdd_oc_i = 0; wake_src_i = 0; cs_wake_i = 0; cmd_vld_i = 0;
    cmd_code_i = 0; wd_cfg_i = 0; wd_trig_i = 0;
  endtask

  task automatic wait_leave(input int m, output int n);
    n = 0;
    while (int'(mode_o) == m && n < 1000) begin
      step();
      n++;
    end
  endtask

  task automatic to_normal(input int per, input bit sby);
    int n;
    wait_leave(0, n);
    wd_cfg_i = 1; wd_period_i = 8'(per);
    if (sby) begin cmd_vld_i = 1; cmd_code_i = 3; end
    step();
    idle();
  endtask

  task automatic cmd(input int code);
    cmd_vld_i = 1; cmd_code_i = 3'(code);
    step();
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int codes[6] = '{0, 1, 2, 3, 6, 7};
    void'($urandom(32'h5eed));
    rst_ni = 0; tick_i = 1; vdd_uv_i = 0; wd_stop_en_i = 0; hs_req_i = 1;
    wd_period_i = 8;
    idle();
    repeat (3) step();
    rst_ni = 1;
    // R1 reset state
    chk(mode_o == 0 && !rst_no && vdd_en_o && !v2_en_o, "R1", mode_o, 0);
    wait_leave(0, n);
    chk(n == RST_T, "R1", n, RST_T);
    chk(mode_o == 1 && rst_no && vdd_en_o && !v2_en_o, "R2", mode_o, 1);
    chk(hs_en_o == 0, "R12", hs_en_o, 0);
    wait_leave(1, n);
    chk(n == NREQ_T, "R3", n, NREQ_T);
    chk(mode_o == 0, "R3", mode_o, 0);
    wait_leave(0, n);
    // configuration in the final tick of the window
    repeat (NREQ_T - 1) step();
    chk(mode_o == 1, "R2", mode_o, 1);
    wd_cfg_i = 1; wd_period_i = 8;
    step(); idle();
    chk(mode_o == 2, "R2", mode_o, 2);
    chk(v2_en_o && vdd_en_o && !vdd_lp_o, "R6", v2_en_o, 1);
    chk(hs_en_o == 1, "R12", hs_en_o, 1);
    // R7 timeout in Normal
    wait_leave(2, n);
    chk(n == 8 && mode_o == 0, "R7", n, 8);
    // R8 early trigger
    to_normal(8, 0);
    wd_trig_i = 1; step(); idle();
    chk(mode_o == 0, "R8", mode_o, 0);
    // R8 open trigger in Standby
    to_normal(8, 1);
    chk(mode_o == 3 && !v2_en_o && vdd_en_o, "R2", mode_o, 3);
    repeat (5) step();
    wd_trig_i = 1; step(); idle();
    repeat (6) step();
    chk(mode_o == 3, "R8", mode_o, 3);
    wait_leave(3, n);
    chk(n == 2 && mode_o == 0, "R7", n, 2);
    // R10 undervoltage beats a command
    to_normal(8, 0);
    vdd_uv_i = 1; cmd_vld_i = 1; cmd_code_i = 4;
    step(); idle();
    chk(mode_o == 0 && !rst_no, "R10", mode_o, 0);
    repeat (6) step();
    chk(mode_o == 0, "R10", mode_o, 0);
    vdd_uv_i = 0;
    wait_leave(0, n);
    chk(n == RST_T, "R1", n, RST_T);
    // Stop with watchdog halted
    to_normal(8, 0);
    cmd(4);
    chk(mode_o == 4 && vdd_lp_o && vdd_en_o && !v2_en_o, "R6", mode_o, 4);
    chk(hs_en_o == 0, "R12", hs_en_o, 0);
    repeat (20) step();
    chk(mode_o == 4, "R9", mode_o, 4);
    cs_wake_i = 1; step(); idle();
    chk(mode_o == 1, "R5", mode_o, 1);
    wait_leave(1, n);
    chk(n == NREQ_T && mode_o == 0, "R3", mode_o, 0);
    // Stop with watchdog running
    to_normal(8, 0);
    wd_stop_en_i = 1;
    cmd(4);
    wait_leave(4, n);
    chk(n == 7 && mode_o == 0, "R9", n, 7);
    wd_stop_en_i = 0;
    // Stop wakes by wake input and overcurrent
    to_normal(8, 0);
    cmd(4);
    wake_src_i = 4'b0100; step(); idle();
    chk(mode_o == 1, "R5", mode_o, 1);
    to_normal(8, 0);
    cmd(4);
    vdd_oc_i = 1; step(); idle();
    chk(mode_o == 1, "R5", mode_o, 1);
    // Sleep
    to_normal(8, 0);
    cmd(5);
    chk(mode_o == 5 && !vdd_en_o && !v2_en_o && !vdd_lp_o, "R6", mode_o, 5);
    cmd_vld_i = 1; cmd_code_i = 2; cs_wake_i = 1; vdd_oc_i = 1; vdd_uv_i = 1;
    step(); idle(); vdd_uv_i = 0;
    step();
    chk(mode_o == 5, "R4", mode_o, 5);
    chk(mode_o == 5, "R11", mode_o, 5);
    for (int b = 0; b < 4; b++) begin
      wake_src_i = 4'(1 << b); step(); idle();
      chk(mode_o == 0, "R4", mode_o, 0);
      wait_leave(0, n);
      wait_leave(1, n);
      chk(n == NREQ_T && mode_o == 5, "R3", mode_o, 5);
    end
    // R11 and R12 random commands in Normal/Standby
    wake_src_i = 4'b1000; step(); idle();
    to_normal(200, 0);
    begin
      int em = 2;
      for (int i = 0; i < 60; i++) begin
        int c = codes[$urandom % 6];
        bit v = 1'($urandom % 2);
        bit h = 1'($urandom % 2);
        cmd_vld_i = v; cmd_code_i = 3'(c); hs_req_i = h;
        step(); idle();
        em = exp_cmd(em, v, c);
        chk(int'(mode_o) == em, "R11", mode_o, em);
        chk(hs_en_o == exp_hs(em, h), "R12", hs_en_o, exp_hs(em, h));
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule